// File: doc/BRIEF.md
# Converter Handshake Sequencer

This block is a clocked digital model of a converter's control and output side. A signed sample word and an unsigned reference word enter on every cycle. A rising edge on `convert_i` captures both words. The block then steps through a fixed output handshake:

- a wait phase;
- a blank phase, in which `status_o` is high and the data bus carries no valid code;
- a show phase, in which the new code and over-range flag are presented while `status_o` stays high;
- a return to idle, which drops `status_o`.

Each phase lasts a whole number of clock cycles, and each length is set by a parameter.

The code is the sample scaled to the reference: floor(sample × 2^BITS / reference). A negative sample clamps the code to zero and raises over-range. A sample above the reference clamps the code to all ones and also raises over-range. The arithmetic sits in one function inside the output stage. Software or a bench can restate it with plain integers.

The host pulses `convert_i` and waits for `status_o` to fall. It reads `data_o` and `over_o` at any time while `data_ok_o` is high.

Top module: `conv_seq`

## Requirements
- R1: For 0 <= sample < reference, the code equals floor(sample × 2^BITS / reference), and `over_o` is 0.
- R2: A negative sample (sign bit set) gives a code of all zeros and `over_o` = 1.
- R3: A sample above the reference gives a code of all ones and `over_o` = 1. A sample equal to the reference gives all ones and `over_o` = 0.
- R4: `status_o` rises exactly TPCS clock edges after the accepted edge. The accepted edge is the first clock edge at which `convert_i` is sampled 1 after being sampled 0 while the block is idle.
- R5: From the rise of `status_o` until the data becomes valid, `data_ok_o` is 0 and `data_o` is forced to all zeros.
- R6: Exactly TPSD edges after `status_o` rises, `data_ok_o` becomes 1. `data_o` and `over_o` then take the result computed from the sample and reference captured at the accepted edge.
- R7: `status_o` falls exactly TPDS edges after the data becomes valid, and the block returns to idle.
- R8: A rising edge on `convert_i` is ignored from the accepted edge until `status_o` has fallen. A level held high starts only one conversion.
- R9: Reset, asynchronous and active low, clears `status_o`, `data_o`, `data_ok_o` and `over_o`, and aborts any conversion in progress.
- R10: `data_o`, `data_ok_o` and `over_o` keep their values outside the two update moments: the rise of `status_o` and the data-valid moment. `over_o` holds its last value through the blank phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convert_i | input | 1 | Conversion request; a rising edge starts a conversion |
| sample_i | input | SW | Signed sample word |
| ref_i | input | RW | Unsigned reference word |
| status_o | output | 1 | High while busy (blank and show phases) |
| data_o | output | BITS | Converted code; zero while blanked |
| data_ok_o | output | 1 | High when `data_o` holds a valid code |
| over_o | output | 1 | Over-range flag of the latest completed conversion |

## Verification
The assertions assume that `convert_i`, `sample_i` and `ref_i` are synchronous to `clk`. They also assume that every phase parameter is at least 1, so the blank and show phases never merge. The stimulus changes inputs only on the falling clock edge, and it holds `convert_i` low for at least one edge before each accepted request. Deliberate rises inside the busy window exercise the ignore rule. The stimulus also covers a held-high level and a reset that arrives mid-conversion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_BLANK = 2'd2,
    PH_SHOW  = 2'd3
  } phase_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/conv_seq_edge.sv
module conv_seq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic convert_i,
  output logic rise_o
);
  logic conv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_d <= 1'b0;
    else        conv_d <= convert_i;
  end

  assign rise_o = convert_i & ~conv_d;

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int TPCS = 2,
  parameter int TPSD = 3,
  parameter int TPDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic accept_o,
  output logic blank_evt_o,
  output logic show_evt_o,
  output logic status_o,
  output logic busy_o
);
  localparam int TMAX = max3(TPCS, TPSD, TPDS);
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  phase_t ph;
  logic [CW-1:0] cnt;
  logic cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign accept_o    = rise_i && (ph == PH_IDLE);
  assign blank_evt_o = (ph == PH_WAIT)  && cnt_zero;
  assign show_evt_o  = (ph == PH_BLANK) && cnt_zero;
  assign status_o    = (ph == PH_BLANK) || (ph == PH_SHOW);
  assign busy_o      = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (rise_i) begin
          ph  <= PH_WAIT;
          cnt <= CW'(TPCS - 1);
        end
        PH_WAIT: if (cnt_zero) begin
          ph  <= PH_BLANK;
          cnt <= CW'(TPSD - 1);
        end else cnt <= cnt - 1'b1;
        PH_BLANK: if (cnt_zero) begin
          ph  <= PH_SHOW;
          cnt <= CW'(TPDS - 1);
        end else cnt <= cnt - 1'b1;
        PH_SHOW: if (cnt_zero) begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R4
  status_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o) |-> $past(busy_o));

  // R7
  status_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o) |-> !busy_o);

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rise_i |=> $stable(ph) || ph == $past(ph) + 2'd1 || ph == PH_IDLE);

endmodule

// File: rtl/conv_seq_out.sv
module conv_seq_out #(
  parameter int BITS = 8,
  parameter int SW   = 12,
  parameter int RW   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_i,
  input  logic                 blank_evt_i,
  input  logic                 show_evt_i,
  input  logic                 busy_i,
  input  logic signed [SW-1:0] sample_i,
  input  logic [RW-1:0]        ref_i,
  output logic [BITS-1:0]      data_o,
  output logic                 data_ok_o,
  output logic                 over_o
);
  localparam int NW = SW - 1 + BITS;
  localparam int QW = (NW > RW) ? NW : RW;

  logic signed [SW-1:0] samp_q;
  logic [RW-1:0]        ref_q;
  logic [BITS:0]        result;

  // returns {over, code}
  function automatic logic [BITS:0] scale_code(input logic signed [SW-1:0] s,
                                               input logic [RW-1:0] r);
    logic [QW-1:0] mag, num, den, quo;
    if (s[SW-1]) return {1'b1, {BITS{1'b0}}};
    mag = QW'(s[SW-2:0]);
    den = QW'(r);
    if (mag > den)  return {1'b1, {BITS{1'b1}}};
    if (mag == den) return {1'b0, {BITS{1'b1}}};
    num = QW'({s[SW-2:0], {BITS{1'b0}}});
    quo = num / den;
    return {1'b0, quo[BITS-1:0]};
  endfunction

  assign result = scale_code(samp_q, ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      ref_q  <= '0;
    end else if (accept_i) begin
      samp_q <= sample_i;
      ref_q  <= ref_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o    <= '0;
      data_ok_o <= 1'b0;
      over_o    <= 1'b0;
    end else if (blank_evt_i) begin
      data_o    <= '0;
      data_ok_o <= 1'b0;
    end else if (show_evt_i) begin
      data_o    <= result[BITS-1:0];
      data_ok_o <= 1'b1;
      over_o    <= result[BITS];
    end
  end

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && $past(busy_i) |-> $stable(samp_q) && $stable(ref_q));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_evt_i && !show_evt_i |=> $stable(data_o) && $stable(over_o) && $stable(data_ok_o));

  // R2
  clamp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ok_o) && over_o |-> (data_o == '0) || (&data_o));

  // R5
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && !data_ok_o |-> data_o == '0);

endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int BITS = 8,
  parameter int SW   = 12,
  parameter int RW   = 12,
  parameter int TPCS = 2,
  parameter int TPSD = 3,
  parameter int TPDS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 convert_i,
  input  logic signed [SW-1:0] sample_i,
  input  logic [RW-1:0]        ref_i,
  output logic                 status_o,
  output logic [BITS-1:0]      data_o,
  output logic                 data_ok_o,
  output logic                 over_o
);
  logic rise_evt;
  logic accept_evt;
  logic blank_evt;
  logic show_evt;
  logic busy;

  conv_seq_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .convert_i (convert_i),
    .rise_o    (rise_evt)
  );

  conv_seq_ctrl #(.TPCS(TPCS), .TPSD(TPSD), .TPDS(TPDS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise_evt),
    .accept_o    (accept_evt),
    .blank_evt_o (blank_evt),
    .show_evt_o  (show_evt),
    .status_o    (status_o),
    .busy_o      (busy)
  );

  conv_seq_out #(.BITS(BITS), .SW(SW), .RW(RW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_evt),
    .blank_evt_i (blank_evt),
    .show_evt_i  (show_evt),
    .busy_i      (busy),
    .sample_i    (sample_i),
    .ref_i       (ref_i),
    .data_o      (data_o),
    .data_ok_o   (data_ok_o),
    .over_o      (over_o)
  );

  // R6
  valid_in_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ok_o) |-> status_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !status_o);

endmodule

// File: tb/test_conv_seq.sv
module test_conv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BITS = 8, SW = 12, RW = 12;
  localparam int TPCS = 2, TPSD = 3, TPDS = 2;
  localparam int TOT = TPCS + TPSD + TPDS;
  localparam int ONES = (1 << BITS) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convert = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic [RW-1:0] refw = '0;
  logic status, data_ok, over;
  logic [BITS-1:0] data;

  int total = 0;
  int bad = 0;
  int prev_data = 0, prev_ok = 0, prev_over = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_seq #(.BITS(BITS), .SW(SW), .RW(RW), .TPCS(TPCS), .TPSD(TPSD), .TPDS(TPDS)) i_conv_seq (
    .clk(clk), .rst_n(rst_n), .convert_i(convert), .sample_i(sample), .ref_i(refw),
    .status_o(status), .data_o(data), .data_ok_o(data_ok), .over_o(over));

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent integer model: returns code, sets ov
  function automatic int model(input int s, input int r, output int ov);
    if (s < 0) begin ov = 1; return 0; end
    if (s > r) begin ov = 1; return ONES; end
    ov = 0;
    if (s == r) return ONES;
    return (s * (1 << BITS)) / r;
  endfunction

  // mode 0: plain pulse, 1: extra rise while busy, 2: convert held high
  task automatic run_conv(input int s, input int r, input int mode, input string tag);
    int exp_code, exp_ov;
    exp_code = model(s, r, exp_ov);
    @(negedge clk);
    convert = 1'b0;
    sample = SW'(s);
    refw = RW'(r);
    @(negedge clk);
    convert = 1'b1;
    for (int k = 1; k <= TOT + 1; k++) begin
      @(negedge clk);
      if (mode != 2 && k == 1) convert = 1'b0;
      if (mode == 1 && k == 3) begin convert = 1'b1; sample = SW'(0); refw = RW'(1); end
      if (mode == 1 && k == 4) convert = 1'b0;
      // R4 R7 status window
      check(int'(status), int'((k-1) >= TPCS && (k-1) < TOT), {tag, " R4/R7 status"});
      if ((k-1) < TPCS) begin
        // R10 old outputs held
        check(int'(data), prev_data, {tag, " R10 data hold"});
        check(int'(data_ok), prev_ok, {tag, " R10 ok hold"});
      end else if ((k-1) < TPCS + TPSD) begin
        // R5 blanked data
        check(int'(data_ok), 0, {tag, " R5 ok low"});
        check(int'(data), 0, {tag, " R5 data zero"});
        check(int'(over), prev_over, {tag, " R10 over hold"});
      end else begin
        // R6 valid result (R1 R2 R3 value)
        check(int'(data_ok), 1, {tag, " R6 ok high"});
        check(int'(data), exp_code, {tag, " R1/R2/R3 code"});
        check(int'(over), exp_ov, {tag, " R1/R2/R3 over"});
      end
    end
    prev_data = exp_code; prev_ok = 1; prev_over = exp_ov;
    if (mode != 0) begin
      // R8 no second conversion follows
      for (int k = 0; k < TOT; k++) begin
        @(negedge clk);
        check(int'(status), 0, {tag, " R8 no restart"});
        check(int'(data), exp_code, {tag, " R8 data kept"});
      end
    end
    convert = 1'b0;
  endtask

  task automatic reset_check(input string tag);
    check(int'(status), 0, {tag, " R9 status"});
    check(int'(data), 0, {tag, " R9 data"});
    check(int'(data_ok), 0, {tag, " R9 ok"});
    check(int'(over), 0, {tag, " R9 over"});
  endtask

  task automatic mid_reset();
    @(negedge clk);
    convert = 1'b0; sample = SW'(-3); refw = RW'(100);
    @(negedge clk);
    convert = 1'b1;
    for (int k = 0; k < TPCS + TPSD + 1; k++) @(negedge clk);
    rst_n = 1'b0;
    convert = 1'b0;
    #1;
    reset_check("midreset");
    @(negedge clk);
    rst_n = 1'b1;
    prev_data = 0; prev_ok = 0; prev_over = 0;
    @(negedge clk);
    reset_check("after_reset");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check("reset");
    rst_n = 1'b1;
    run_conv(1000, 4000, 0, "mid");           // R1 -> 64
    run_conv(1, 4095, 0, "tiny");             // R1 -> 0
    run_conv(2046, 2047, 0, "near_top");      // R1 -> 255
    run_conv(-5, 4000, 0, "negative");        // R2
    run_conv(-2048, 10, 0, "most_negative");  // R2
    run_conv(2047, 1000, 0, "above");         // R3
    run_conv(1500, 1500, 0, "equal");         // R3 equal
    run_conv(5, 0, 0, "zero_ref");            // R3 above zero reference
    run_conv(333, 1000, 1, "ignore_busy");    // R8 mid rise ignored
    run_conv(700, 2800, 2, "held_high");      // R8 held level
    mid_reset();                              // R9
    run_conv(123, 456, 0, "post_reset");      // R1 after reset
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule